// File: doc/BRIEF.md
# Queued Input Capture Unit

This block timestamps edges on a set of input pins. Each channel watches one pin through a two-flop synchroniser and an edge qualifier. On a qualified edge it copies the value of a free-running timer, supplied from outside, into its capture register. The lower half of the channels also has a holding register. That register can be chained behind the capture register to form a two-deep queue, so software can collect two timestamps per service call.

A control word selects the operating mode:
- The buffers can be off, the channels can run as queues, or the holding registers can load together on a software latch command.
- A paired-flag option makes a queued channel raise its flag only when its holding register is filled. One interrupt then stands for two timestamps.
- Per-pair routing lets a lower pin drive the capture action of the matching upper channel.

Per-channel no-overwrite bits protect unread data. Flags are cleared by writing ones, and a single interrupt line reports any enabled flag. Software reaches everything through a simple word-wide read/write port whose read data appears one cycle after the request.

Top module: `qcap_timer`

## Requirements
- R1: After reset the control word, edge selects, no-overwrite bits, flags, interrupt enables, capture and holding registers all read 0, and `irq` is 0.
- R2: With `test_mode` low, the control word (address 0) accepts only the first write after reset and ignores later writes. With `test_mode` high it stays writable.
- R3: Each channel has a 2-bit edge select at bits [2i+1:2i] of address 1, with 00 = off, 01 = rising, 10 = falling and 11 = both. A qualified edge loads the timer value into the capture register of that channel, which is read at address 8+i.
- R4: While the buffer enable (control bit 9) is 0, the holding registers (address 16+i) never change.
- R5: Queue mode is control bit 9 = 1 with bit 10 = 0. In queue mode, an edge that arrives while the capture register holds an unread value first moves that value to the holding register and then loads the capture register. If the capture register has been read, the edge only loads it.
- R6: When the paired-flag bit (control bit 8) is 0, every accepted capture sets the flag of that channel (address 3, bit i).
- R7: When the paired-flag bit is 1 and the block is in queue mode, a flag sets only when the holding register of its channel is loaded by an edge. When the paired-flag bit is 1 outside queue mode, flags behave as in R6.
- R8: A channel is protected when its bit in address 2 is 1. An edge on a protected channel is ignored whenever accepting it would overwrite an unread register: the capture register outside queue mode, or the holding register in queue mode when both registers are full. Reading a register marks it as read.
- R9: When control bit k (k below half the channel count) is 1, the qualified edge of pin k drives the capture action of channel k+half, and the own pin of that upper channel is ignored.
- R10: Writing 1 to a bit of address 3 clears that flag, and writing 0 leaves it unchanged. `irq` is the OR over channels of flag AND enable, where the enables are at address 4, bit i.
- R11: With control bits 9 and 10 both set, a write to address 5 copies every lower channel's capture register into its holding register. In this latch mode, edges do not move data into the holding registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_mode | input | 1 | Keeps the control word writable |
| tmr | input | TW | Free-running timer value |
| pins | input | NCH | Asynchronous capture inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Register address |
| wdata | input | TW | Write data |
| rdata | output | TW | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Combined enabled flags, registered |

## Verification
The hardest case to reach is a protected queued channel whose capture and holding registers are both full. A further edge must then be dropped without touching either register or the flag. Once software has read both registers, the next edge must only reload the capture register. The stimulus drives three edges back to back on a protected channel, reads both registers, and then drives two more edges. This shows that the third timestamp was lost, that the refilled pair carries the later stamps, and that the flag rises only on the second edge of each pair. A second, unprotected channel runs the same pattern to show that its queue keeps moving instead.

// File: rtl/qcap_pkg.sv
package qcap_pkg;
  localparam int A_CTRL  = 0;
  localparam int A_EDGE  = 1;
  localparam int A_NOVW  = 2;
  localparam int A_FLAG  = 3;
  localparam int A_IEN   = 4;
  localparam int A_LATCH = 5;
  localparam int A_CAP   = 8;
  localparam int A_HOLD  = 16;
  localparam int CB_PAIRF = 8;
  localparam int CB_BUF   = 9;
  localparam int CB_LATQ  = 10;
endpackage

// File: rtl/qcap_edge.sv
module qcap_edge (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin,
  input  logic [1:0] sel,
  output logic       det
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  // sel[0] qualifies rising, sel[1] qualifies falling
  assign det = (s2 & ~s3 & sel[0]) | (~s2 & s3 & sel[1]);
endmodule

// File: rtl/qcap_chan.sv
module qcap_chan #(
  parameter int TW       = 16,
  parameter bit HAS_HOLD = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trig,
  input  logic [TW-1:0] tmr,
  input  logic          queue_on,
  input  logic          pairf_on,
  input  logic          novw,
  input  logic          rd_cap,
  input  logic          rd_hold,
  input  logic          latch_cmd,
  output logic [TW-1:0] cap_q,
  output logic [TW-1:0] hold_q,
  output logic          cap_full,
  output logic          hold_full,
  output logic          set_flag
);
  logic take, move, lmove;

  always_comb begin
    take = 1'b0;
    move = 1'b0;
    if (trig) begin
      if (HAS_HOLD && queue_on) begin
        if (cap_full) begin
          if (!(novw && hold_full)) begin
            move = 1'b1;
            take = 1'b1;
          end
        end else begin
          take = 1'b1;
        end
      end else if (!(novw && cap_full)) begin
        take = 1'b1;
      end
    end
    lmove    = HAS_HOLD && latch_cmd;
    set_flag = pairf_on ? move : take;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q     <= '0;
      hold_q    <= '0;
      cap_full  <= 1'b0;
      hold_full <= 1'b0;
    end else begin
      if (take) cap_q <= tmr;
      cap_full <= take | (cap_full & ~rd_cap);
      if (move || lmove) hold_q <= cap_q;
      hold_full <= move | lmove | (hold_full & ~rd_hold);
    end
  end
endmodule

// File: rtl/qcap_timer.sv
module qcap_timer
  import qcap_pkg::*;
#(
  parameter int NCH = 8,
  parameter int TW  = 16,
  parameter int AW  = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           test_mode,
  input  logic [TW-1:0]  tmr,
  input  logic [NCH-1:0] pins,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic [TW-1:0]  wdata,
  output logic [TW-1:0]  rdata,
  output logic           irq
);
  localparam int NQ = NCH / 2;
  localparam logic [TW-1:0] CTRL_MASK =
    TW'((1 << NQ) - 1) | TW'(1 << CB_PAIRF) | TW'(1 << CB_BUF) | TW'(1 << CB_LATQ);

  logic [TW-1:0]     ctrl_q;
  logic              ctrl_locked;
  logic [2*NCH-1:0]  edge_q;
  logic [NCH-1:0]    novw_q, flags_q, ien_q;
  logic [NCH-1:0]    det, trig, set_flag, cap_full, hold_full, rd_cap, rd_hold;
  logic [NCH*TW-1:0] cap_bus, hold_bus;
  logic [TW-1:0]     rmux;
  logic              queue_on, pairf_on, latch_cmd, wr_ctrl, wr_flag;

  assign queue_on  = ctrl_q[CB_BUF] & ~ctrl_q[CB_LATQ];
  assign pairf_on  = ctrl_q[CB_PAIRF] & queue_on;
  assign latch_cmd = wr_en && (addr == AW'(A_LATCH)) && ctrl_q[CB_BUF] && ctrl_q[CB_LATQ];
  assign wr_ctrl   = wr_en && (addr == AW'(A_CTRL)) && (test_mode || !ctrl_locked);
  assign wr_flag   = wr_en && (addr == AW'(A_FLAG));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam bit HH = (i < NQ);

    qcap_edge u_edge (
      .clk (clk),
      .rst (rst),
      .pin (pins[i]),
      .sel (edge_q[2*i+1:2*i]),
      .det (det[i])
    );

    if (i >= NQ) begin : g_shr
      assign trig[i] = ctrl_q[i-NQ] ? det[i-NQ] : det[i];
    end else begin : g_own
      assign trig[i] = det[i];
    end

    assign rd_cap[i]  = rd_en && (addr == AW'(A_CAP + i));
    assign rd_hold[i] = rd_en && (addr == AW'(A_HOLD + i));

    qcap_chan #(.TW(TW), .HAS_HOLD(HH)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .trig      (trig[i]),
      .tmr       (tmr),
      .queue_on  (queue_on & HH),
      .pairf_on  (pairf_on & HH),
      .novw      (novw_q[i]),
      .rd_cap    (rd_cap[i]),
      .rd_hold   (rd_hold[i]),
      .latch_cmd (latch_cmd),
      .cap_q     (cap_bus[i*TW +: TW]),
      .hold_q    (hold_bus[i*TW +: TW]),
      .cap_full  (cap_full[i]),
      .hold_full (hold_full[i]),
      .set_flag  (set_flag[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= '0;
      ctrl_locked <= 1'b0;
      edge_q      <= '0;
      novw_q      <= '0;
      ien_q       <= '0;
      flags_q     <= '0;
      irq         <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= wdata & CTRL_MASK;
        if (!test_mode) ctrl_locked <= 1'b1;
      end
      if (wr_en && addr == AW'(A_EDGE)) edge_q <= wdata[2*NCH-1:0];
      if (wr_en && addr == AW'(A_NOVW)) novw_q <= wdata[NCH-1:0];
      if (wr_en && addr == AW'(A_IEN))  ien_q  <= wdata[NCH-1:0];
      flags_q <= (flags_q & ~(wr_flag ? wdata[NCH-1:0] : '0)) | set_flag;
      irq     <= |(flags_q & ien_q);
    end
  end

  always_comb begin
    rmux = '0;
    if (addr == AW'(A_CTRL)) rmux = ctrl_q;
    if (addr == AW'(A_EDGE)) rmux = TW'(edge_q);
    if (addr == AW'(A_NOVW)) rmux = TW'(novw_q);
    if (addr == AW'(A_FLAG)) rmux = TW'(flags_q);
    if (addr == AW'(A_IEN))  rmux = TW'(ien_q);
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(A_CAP + i))  rmux = cap_bus[i*TW +: TW];
      if (addr == AW'(A_HOLD + i)) rmux = hold_bus[i*TW +: TW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= rmux;
  end
endmodule

// File: rtl/qcap_timer_chk.sv
module qcap_timer_chk
  import qcap_pkg::*;
#(
  parameter int NCH = 8,
  parameter int TW  = 16,
  parameter int AW  = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           test_mode,
  input logic           wr_en,
  input logic           rd_en,
  input logic [AW-1:0]  addr,
  input logic [TW-1:0]  wdata,
  input logic [TW-1:0]  ctrl_q,
  input logic           ctrl_locked,
  input logic [NCH-1:0] flags_q,
  input logic [NCH-1:0] set_flag,
  input logic [NCH-1:0] novw_q,
  input logic [NCH-1:0] cap_full,
  input logic [NCH-1:0] hold_full,
  input logic [NCH*TW-1:0] cap_bus,
  input logic [NCH*TW-1:0] hold_bus
);
  logic q_mode;
  assign q_mode = ctrl_q[CB_BUF] & ~ctrl_q[CB_LATQ];

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (flags_q == '0) && (ctrl_q == '0));

  // R2
  ctrl_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (!test_mode && ctrl_locked) |=> $stable(ctrl_q));

  // R4
  nobuf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[CB_BUF] |=> $stable(hold_bus));

  // R7
  pairflag_chk: assert property (@(posedge clk) disable iff (rst)
    (q_mode && ctrl_q[CB_PAIRF] && !cap_full[0] && !flags_q[0]) |=> !flags_q[0]);

  // R8
  novw_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (q_mode && novw_q[0] && cap_full[0] && hold_full[0] && !rd_en)
      |=> ($stable(hold_bus[TW-1:0]) && $stable(cap_bus[TW-1:0])));

  for (genvar i = 0; i < NCH; i++) begin : g_w1c
    // R10
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == AW'(A_FLAG) && wdata[i] && !set_flag[i]) |=> !flags_q[i]);
  end
endmodule

bind qcap_timer qcap_timer_chk #(.NCH(NCH), .TW(TW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .test_mode(test_mode), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .ctrl_q(ctrl_q), .ctrl_locked(ctrl_locked),
  .flags_q(flags_q), .set_flag(set_flag), .novw_q(novw_q), .cap_full(cap_full),
  .hold_full(hold_full), .cap_bus(cap_bus), .hold_bus(hold_bus)
);

// File: tb/sim_qcap_timer.sv
`timescale 1ns/1ps
module sim_qcap_timer;
  localparam int NCH = 8, TW = 16, AW = 5;
  localparam int NV = 17;
  // {op, ch, val, exp}; op 0 edge+flag check, 1 read cap, 2 read hold, 3 clear flags
  localparam logic [36:0] VEC [0:NV-1] = '{
    {2'd0, 3'd0, 16'h1111, 16'h0000},
    {2'd0, 3'd0, 16'h2222, 16'h0001},
    {2'd0, 3'd0, 16'h3333, 16'h0001},
    {2'd2, 3'd0, 16'h0000, 16'h1111},
    {2'd1, 3'd0, 16'h0000, 16'h2222},
    {2'd3, 3'd0, 16'h0001, 16'h0000},
    {2'd0, 3'd0, 16'h4444, 16'h0000},
    {2'd0, 3'd0, 16'h5555, 16'h0001},
    {2'd2, 3'd0, 16'h0000, 16'h4444},
    {2'd1, 3'd0, 16'h0000, 16'h5555},
    {2'd3, 3'd0, 16'h0001, 16'h0000},
    {2'd0, 3'd1, 16'h0A0A, 16'h0000},
    {2'd0, 3'd1, 16'h0B0B, 16'h0001},
    {2'd0, 3'd1, 16'h0C0C, 16'h0001},
    {2'd2, 3'd1, 16'h0000, 16'h0B0B},
    {2'd1, 3'd1, 16'h0000, 16'h0C0C},
    {2'd3, 3'd0, 16'h0002, 16'h0000}
  };

  logic clk = 1'b0, rst = 1'b1, test_mode = 1'b0;
  logic [TW-1:0] tmr = '0;
  logic [NCH-1:0] pins = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [TW-1:0] wdata = '0;
  logic [TW-1:0] rdata;
  logic irq;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  qcap_timer #(.NCH(NCH), .TW(TW), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .test_mode(test_mode), .tmr(tmr), .pins(pins),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [TW-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [TW-1:0] d);
    @(negedge clk); rd_en = 1'b1; addr = AW'(a);
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse(input int ch, input logic [TW-1:0] stamp);
    @(negedge clk); tmr = stamp; pins[ch] = ~pins[ch];
    repeat (6) @(negedge clk);
  endtask

  task automatic rchk(input int a, input logic [TW-1:0] exp, input string req);
    logic [TW-1:0] d;
    rd(a, d);
    chk(d == exp, req, int'(d), int'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [TW-1:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rchk(0, 16'h0000, "R1 ctrl");
    rchk(3, 16'h0000, "R1 flags");
    rchk(8, 16'h0000, "R1 cap0");
    rchk(16, 16'h0000, "R1 hold0");
    chk(irq == 1'b0, "R1 irq", int'(irq), 0);
    // R2 write once in normal mode, writable in test mode
    wr(0, 16'h0001);
    wr(0, 16'h0200);
    rchk(0, 16'h0001, "R2 locked");
    test_mode = 1'b1;
    wr(0, 16'h0300);
    rchk(0, 16'h0300, "R2 test_mode");

    // table: queue mode, paired flags, ch0 protected, ch1 not
    wr(1, 16'hFFFF);
    wr(2, 16'h0001);
    for (int k = 0; k < NV; k++) begin
      logic [1:0] op;
      int ch;
      logic [TW-1:0] val, exp;
      op = VEC[k][36:35]; ch = int'(VEC[k][34:32]);
      val = VEC[k][31:16]; exp = VEC[k][15:0];
      case (op)
        2'd0: begin
          pulse(ch, val);
          rd(3, d);
          chk(d[ch] == exp[0], "R7 flag on holding latch", int'(d[ch]), int'(exp[0]));
        end
        2'd1: rchk(8 + ch, exp, "R8 capture value");
        2'd2: rchk(16 + ch, exp, "R5 holding value");
        default: wr(3, val);
      endcase
    end

    // R3 edge qualifier
    wr(0, 16'h0000); wr(2, 16'h0000); wr(3, 16'h00FF);
    wr(1, 16'hFFDF);
    pulse(2, 16'h0100); rchk(10, 16'h0100, "R3 rising taken");
    rd(3, d); chk(d[2] == 1'b1, "R6 flag per capture", int'(d[2]), 1);
    pulse(2, 16'h0200); rchk(10, 16'h0100, "R3 falling ignored");
    wr(1, 16'hFFEF);
    pulse(2, 16'h0300); rchk(10, 16'h0100, "R3 rising ignored");
    pulse(2, 16'h0400); rchk(10, 16'h0400, "R3 falling taken");
    wr(1, 16'hFFCF);
    pulse(2, 16'h0500); rchk(10, 16'h0400, "R3 off");
    wr(1, 16'hFFFF);

    // R4 / R7 paired flag outside queue mode
    wr(0, 16'h0100); wr(3, 16'h00FF);
    pulse(0, 16'h0600);
    rd(3, d); chk(d[0] == 1'b1, "R7 no queue flag", int'(d[0]), 1);
    wr(3, 16'h0001);
    pulse(0, 16'h0610);
    rd(3, d); chk(d[0] == 1'b1, "R7 no queue flag again", int'(d[0]), 1);
    rchk(16, 16'h4444, "R4 hold untouched");
    rchk(8, 16'h0610, "R4 capture only");

    // R6 queue mode with per-edge flags
    wr(0, 16'h0200); wr(3, 16'h00FF);
    pulse(3, 16'h0700);
    rd(3, d); chk(d[3] == 1'b1, "R6 first edge flag", int'(d[3]), 1);
    pulse(3, 16'h0710);
    rchk(19, 16'h0700, "R5 moved to hold");
    rchk(11, 16'h0710, "R5 capture reload");

    // R9 sharing pin 0 onto channel 4
    wr(0, 16'h0001); wr(3, 16'h00FF);
    pulse(0, 16'h0777);
    rchk(12, 16'h0777, "R9 shared capture");
    pulse(4, 16'h0888);
    rchk(12, 16'h0777, "R9 own pin ignored");
    rd(3, d); chk(d[4] == 1'b1, "R9 shared flag", int'(d[4]), 1);

    // R10 W1C and irq
    wr(4, 16'h0010);
    repeat (3) @(negedge clk);
    chk(irq == 1'b1, "R10 irq set", int'(irq), 1);
    wr(3, 16'h0000);
    rchk(3, 16'h0011, "R10 zero write keeps");
    wr(3, 16'h0010);
    rchk(3, 16'h0001, "R10 one clears");
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R10 irq clear", int'(irq), 0);

    // R11 latch mode
    wr(0, 16'h0600);
    wr(5, 16'h0001);
    rchk(16, 16'h0777, "R11 latch copy");
    pulse(0, 16'h0999);
    rchk(16, 16'h0777, "R11 edge no move");
    rchk(8, 16'h0999, "R11 capture");

    // R8 protection outside queue mode on channel 5
    wr(0, 16'h0000); wr(2, 16'h0020);
    pulse(5, 16'h0A00);
    pulse(5, 16'h0B00);
    rchk(13, 16'h0A00, "R8 unread kept");
    pulse(5, 16'h0C00);
    rchk(13, 16'h0C00, "R8 after read");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule